// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block is the miss handler that sits behind a translation lookaside buffer. Given a virtual address, the physical base of the root table, a translation-enable bit and the size of physical memory, it follows a four-level radix tree of 64-bit entries in memory and returns one leaf entry that the buffer can install directly. Memory is reached through a simple read port with at most one read in flight. Each read is bounds-checked against the memory size before it is issued.

A leaf found above the bottom level maps a large region. The walker rewrites it as an equivalent 4 KiB leaf by OR-ing the virtual page number bits below that level into the physical page field. With translation off, no memory is touched and an identity leaf carrying every permission is returned. Every failure comes back with a fault flag and an all-zero entry, whose leaf flag is therefore clear. The failures are an out-of-range entry address, an entry that is neither leaf nor table, and a tree that is still descending after four levels.

The controller has four states. IDLE holds ready high and accepts a request: it goes to DONE when translation is off, and to READ otherwise. READ presents the entry address: it goes to DONE with a fault when the address is not below the memory size, and to WAIT otherwise, having issued the read. WAIT holds until the read data is acknowledged: a leaf goes to DONE, a table descriptor goes back to READ one level down (or to DONE with a fault after the last level), and any other entry goes to DONE with a fault. DONE shows the response for one cycle and returns to IDLE.

Top module: `pt_walk_unit`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `rsp_valid` and `mem_rd_valid` are 0.
- R2: With `req_xlate_on` = 0, the response comes back with no memory read, `rsp_fault` = 0, and entry = (vaddr with bits 11:0 cleared) | 0x3F2. That sets leaf flag bit 1 and permission bits 9:4.
- R3: Level L (0 to 3) uses shift s = 27 − 9·L and index i = vaddr[12+s +: 9]. It reads the entry at base + 8·i, and the base for level 0 is `req_root`.
- R4: If the entry address at any level is not below `req_mem_limit`, the walk ends with a fault and no read is issued for that level.
- R5: An entry with bit 1 set is a leaf, whatever bit 0 holds. The result is entry | ((vaddr[63:12] & (2^s − 1)) << 12), and `rsp_fault` = 0.
- R6: An entry with bits 1 and 0 both clear ends the walk with a fault.
- R7: An entry with bit 1 clear and bit 0 set is a table descriptor. The next level's base is that entry with bits 11:0 cleared.
- R8: A table descriptor read at level 3 ends the walk with a fault.
- R9: Every fault response has `rsp_fault` = 1 and `rsp_entry` = 0.
- R10: At most one read is outstanding. `mem_rd_valid` is high for a single cycle per level, never while idle, and the number of reads equals the number of levels visited.
- R11: `rsp_valid` is a one-cycle pulse. While a walk is in progress `req_ready` is low and a held `req_valid` with new request fields has no effect on the result.
- R12: The response appears 1 cycle after acceptance when translation is off. Otherwise each level whose read is issued adds READ and WAIT cycles, a level that fails the bounds test adds one cycle, and one further cycle brings the result to DONE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 64 | Virtual address to translate |
| req_root | input | 64 | Physical base of the level-0 table |
| req_xlate_on | input | 1 | 1 = walk the tree, 0 = identity mapping |
| req_mem_limit | input | 64 | Size of physical memory in bytes |
| mem_rd_valid | output | 1 | Read request, one cycle |
| mem_rd_addr | output | 64 | Byte address of the entry to read |
| mem_rd_ack | input | 1 | Read data valid |
| mem_rd_data | input | 64 | Entry read from memory |
| rsp_valid | output | 1 | Result valid, one cycle |
| rsp_fault | output | 1 | Walk failed |
| rsp_entry | output | 64 | Leaf entry, or zero on a fault |

## Verification
The bench's memory model raises the acknowledge in the WAIT cycle that follows each READ. This fixes every response time exactly. With translation off, the response is due 1 cycle after acceptance. A walk ending at a leaf, an invalid entry or the level limit is due 1 + 2·(levels read) cycles after acceptance, and a bounds fault 1 more cycle after the reads before it. The bench counts falling edges from acceptance until `rsp_valid`, and compares that count, the number of reads and the returned entry with a bench reference walk over the same memory image. The comparison happens only on the cycle the pulse is due, and the cycle after is checked for the return to idle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WAIT,
        ST_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        EK_INVALID,
        EK_TABLE,
        EK_LEAF
    } entry_kind_e;

    // entry flag positions that the decoder and identity builder rely on
    localparam int unsigned FLAG_TABLE = 0;
    localparam int unsigned FLAG_LEAF  = 1;
    localparam int unsigned PERM_LSB   = 4;
    localparam int unsigned PERM_W     = 6;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int unsigned ADDR_W     = 64,
    parameter int unsigned PG_SHIFT   = 12,
    parameter int unsigned IDX_W      = 9,
    parameter int unsigned LEVELS     = 4,
    parameter int unsigned ENTRY_LOG2 = 3,
    parameter int unsigned LVL_W      = 2
) (
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] limit,
    input  logic [LVL_W-1:0]  level,
    output logic [ADDR_W-1:0] entry_addr,
    output logic              in_range
);

    logic [IDX_W-1:0] idx_lvl [LEVELS];
    logic [IDX_W-1:0] idx_sel;
    logic             unused_vaddr;

    // one index slice per level; level 0 takes the highest slice
    for (genvar l = 0; l < LEVELS; l++) begin : g_idx
        localparam int unsigned SH = (LEVELS - 1 - l) * IDX_W;
        assign idx_lvl[l] = vaddr[PG_SHIFT + SH +: IDX_W];
    end

    assign idx_sel      = idx_lvl[level];
    assign entry_addr   = base + (ADDR_W'(idx_sel) << ENTRY_LOG2);
    assign in_range     = entry_addr < limit;
    assign unused_vaddr = ^vaddr;

endmodule

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
    import ptw_pkg::*;
#(
    parameter int unsigned ADDR_W   = 64,
    parameter int unsigned PG_SHIFT = 12,
    parameter int unsigned IDX_W    = 9,
    parameter int unsigned LEVELS   = 4,
    parameter int unsigned LVL_W    = 2
) (
    input  logic [ADDR_W-1:0] entry,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [LVL_W-1:0]  level,
    output entry_kind_e       kind,
    output logic [ADDR_W-1:0] leaf_out,
    output logic [ADDR_W-1:0] next_base
);

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] vpn;
    logic [ADDR_W-1:0] fold [LEVELS];

    assign vpn = vaddr >> PG_SHIFT;

    // page-number bits below each level, moved up into the frame field
    for (genvar l = 0; l < LEVELS; l++) begin : g_fold
        localparam int unsigned       SH  = (LEVELS - 1 - l) * IDX_W;
        localparam logic [ADDR_W-1:0] MSK = (ONE << SH) - ONE;
        assign fold[l] = (vpn & MSK) << PG_SHIFT;
    end

    always_comb begin
        if (entry[FLAG_LEAF]) begin
            kind = EK_LEAF;
        end else if (entry[FLAG_TABLE]) begin
            kind = EK_TABLE;
        end else begin
            kind = EK_INVALID;
        end
    end

    assign leaf_out  = entry | fold[level];
    assign next_base = {entry[ADDR_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
#(
    parameter int unsigned ADDR_W   = 64,
    parameter int unsigned PG_SHIFT = 12,
    parameter int unsigned LEVELS   = 4,
    parameter int unsigned LVL_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [ADDR_W-1:0] req_root,
    input  logic              req_xlate_on,
    input  logic [ADDR_W-1:0] req_mem_limit,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] entry_addr,
    input  logic              in_range,
    input  logic              mem_rd_ack,
    input  entry_kind_e       kind,
    input  logic [ADDR_W-1:0] leaf_out,
    input  logic [ADDR_W-1:0] next_base,
    output logic              mem_rd_valid,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [ADDR_W-1:0] rsp_entry,
    output logic [ADDR_W-1:0] vaddr_q,
    output logic [ADDR_W-1:0] base_q,
    output logic [ADDR_W-1:0] limit_q,
    output logic [LVL_W-1:0]  level_q
);

    localparam logic [ADDR_W-1:0] ONE         = {{(ADDR_W-1){1'b0}}, 1'b1};
    localparam logic [ADDR_W-1:0] LOW_MASK    = (ONE << PG_SHIFT) - ONE;
    localparam logic [ADDR_W-1:0] PERM_MASK   = ((ONE << PERM_W) - ONE) << PERM_LSB;
    localparam logic [ADDR_W-1:0] IDENT_FLAGS = PERM_MASK | (ONE << FLAG_LEAF);
    localparam logic [LVL_W-1:0]  LAST_LVL    = LVL_W'(LEVELS - 1);

    walk_state_e       state, state_nxt;
    logic [ADDR_W-1:0] result_q;
    logic              fault_q;
    logic [ADDR_W-1:0] ident;
    logic              last_lvl;

    assign ident    = (req_vaddr & ~LOW_MASK) | IDENT_FLAGS;
    assign last_lvl = (level_q == LAST_LVL);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nxt = req_xlate_on ? ST_READ : ST_DONE;
            ST_READ: state_nxt = in_range ? ST_WAIT : ST_DONE;
            ST_WAIT: begin
                if (mem_rd_ack) begin
                    if (kind == EK_TABLE && !last_lvl) begin
                        state_nxt = ST_READ;
                    end else begin
                        state_nxt = ST_DONE;
                    end
                end
            end
            ST_DONE: state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // walk registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q  <= '0;
            base_q   <= '0;
            limit_q  <= '0;
            level_q  <= '0;
            result_q <= '0;
            fault_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        vaddr_q  <= req_vaddr;
                        base_q   <= req_root;
                        limit_q  <= req_mem_limit;
                        level_q  <= '0;
                        fault_q  <= 1'b0;
                        result_q <= req_xlate_on ? '0 : ident;
                    end
                end
                ST_READ: begin
                    if (!in_range) begin
                        fault_q  <= 1'b1;
                        result_q <= '0;
                    end
                end
                ST_WAIT: begin
                    if (mem_rd_ack) begin
                        case (kind)
                            EK_LEAF: begin
                                result_q <= leaf_out;
                            end
                            EK_TABLE: begin
                                base_q <= next_base;
                                if (last_lvl) begin
                                    fault_q  <= 1'b1;
                                    result_q <= '0;
                                end else begin
                                    level_q <= level_q + LVL_W'(1);
                                end
                            end
                            default: begin
                                fault_q  <= 1'b1;
                                result_q <= '0;
                            end
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready    = (state == ST_IDLE);
        mem_rd_valid = (state == ST_READ) && in_range;
        mem_rd_addr  = entry_addr;
        rsp_valid    = (state == ST_DONE);
        rsp_fault    = fault_q;
        rsp_entry    = result_q;
    end

    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |=> !mem_rd_valid) else $error("read held"); // R10
    AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_rd_valid) else $error("read while idle"); // R10
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready)) else $error("response not a pulse"); // R11
    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_entry == '0)) else $error("fault entry nonzero"); // R9
    AST_LEAF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> rsp_entry[FLAG_LEAF]) else $error("result lacks leaf flag"); // R5
    AST_TABLE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && mem_rd_ack && kind == EK_TABLE && !last_lvl)
        |=> (state == ST_READ && base_q[PG_SHIFT-1:0] == '0)) else $error("table step wrong"); // R7

endmodule

// File: rtl/pt_walk_unit.sv
module pt_walk_unit
    import ptw_pkg::*;
#(
    parameter int unsigned ADDR_W     = 64,
    parameter int unsigned PG_SHIFT   = 12,
    parameter int unsigned IDX_W      = 9,
    parameter int unsigned LEVELS     = 4,
    parameter int unsigned ENTRY_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [ADDR_W-1:0] req_root,
    input  logic              req_xlate_on,
    input  logic [ADDR_W-1:0] req_mem_limit,
    output logic              mem_rd_valid,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_ack,
    input  logic [ADDR_W-1:0] mem_rd_data,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [ADDR_W-1:0] rsp_entry
);

    localparam int unsigned LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;

    logic [ADDR_W-1:0] vaddr_q, base_q, limit_q;
    logic [LVL_W-1:0]  level_q;
    logic [ADDR_W-1:0] entry_addr, leaf_out, next_base;
    logic              in_range;
    entry_kind_e       kind;

    ptw_addr_gen #(
        .ADDR_W(ADDR_W), .PG_SHIFT(PG_SHIFT), .IDX_W(IDX_W),
        .LEVELS(LEVELS), .ENTRY_LOG2(ENTRY_LOG2), .LVL_W(LVL_W)
    ) u_addr (
        .vaddr      (vaddr_q),
        .base       (base_q),
        .limit      (limit_q),
        .level      (level_q),
        .entry_addr (entry_addr),
        .in_range   (in_range)
    );

    ptw_entry_eval #(
        .ADDR_W(ADDR_W), .PG_SHIFT(PG_SHIFT), .IDX_W(IDX_W),
        .LEVELS(LEVELS), .LVL_W(LVL_W)
    ) u_eval (
        .entry     (mem_rd_data),
        .vaddr     (vaddr_q),
        .level     (level_q),
        .kind      (kind),
        .leaf_out  (leaf_out),
        .next_base (next_base)
    );

    ptw_ctrl #(
        .ADDR_W(ADDR_W), .PG_SHIFT(PG_SHIFT), .LEVELS(LEVELS), .LVL_W(LVL_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_vaddr     (req_vaddr),
        .req_root      (req_root),
        .req_xlate_on  (req_xlate_on),
        .req_mem_limit (req_mem_limit),
        .req_ready     (req_ready),
        .entry_addr    (entry_addr),
        .in_range      (in_range),
        .mem_rd_ack    (mem_rd_ack),
        .kind          (kind),
        .leaf_out      (leaf_out),
        .next_base     (next_base),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_addr   (mem_rd_addr),
        .rsp_valid     (rsp_valid),
        .rsp_fault     (rsp_fault),
        .rsp_entry     (rsp_entry),
        .vaddr_q       (vaddr_q),
        .base_q        (base_q),
        .limit_q       (limit_q),
        .level_q       (level_q)
    );

endmodule

// File: tb/test_pt_walk_unit.sv
module test_pt_walk_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic [63:0] req_root = '0;
    logic        req_xlate_on = 1'b0;
    logic [63:0] req_mem_limit = '0;
    logic        mem_rd_valid;
    logic [63:0] mem_rd_addr;
    logic        mem_rd_ack;
    logic [63:0] mem_rd_data;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [63:0] rsp_entry;

    logic [63:0] mem [0:4095];
    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    pt_walk_unit i_pt_walk_unit (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_root(req_root),
        .req_xlate_on(req_xlate_on), .req_mem_limit(req_mem_limit),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_entry(rsp_entry)
    );

    // memory: data and acknowledge one cycle after the read strobe
    initial begin
        bit          pend;
        logic [63:0] pdata;
        pend = 1'b0;
        pdata = '0;
        mem_rd_ack = 1'b0;
        mem_rd_data = '0;
        forever begin
            @(negedge clk);
            mem_rd_ack  = pend;
            mem_rd_data = pend ? pdata : 64'hDEAD_BEEF_0BAD_F00D;
            pend  = mem_rd_valid;
            pdata = mem[mem_rd_addr[14:3]];
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void ref_walk(input logic [63:0] va, input logic [63:0] root,
                                     input logic [63:0] lim, input bit on,
                                     output logic [63:0] ent, output bit flt,
                                     output int lat, output int rds);
        logic [63:0] base, a, d;
        int sh;
        lat = 1; rds = 0; ent = '0; flt = 1'b1;
        if (!on) begin
            ent = (va & ~64'hFFF) | 64'h3F2;
            flt = 1'b0;
            return;
        end
        base = root;
        for (int l = 0; l < 4; l++) begin
            sh = 27 - 9 * l;
            a = base + (((va >> (12 + sh)) & 64'h1FF) << 3);
            if (a >= lim) begin
                lat += 1;
                return;
            end
            lat += 2;
            rds++;
            d = mem[a[14:3]];
            if (d[1]) begin
                ent = d | (((va >> 12) & ((64'd1 << sh) - 64'd1)) << 12);
                flt = 1'b0;
                return;
            end
            if (!d[0]) return;
            base = {d[63:12], 12'h000};
        end
    endfunction

    task automatic walk(input logic [63:0] va, input logic [63:0] root, input logic [63:0] lim,
                        input bit on, input bit poke, input string tag);
        logic [63:0] e_ent;
        bit          e_flt;
        int          e_lat, e_rd;
        int          lat, rd;
        ref_walk(va, root, lim, on, e_ent, e_flt, e_lat, e_rd);
        @(negedge clk);
        req_vaddr = va; req_root = root; req_mem_limit = lim;
        req_xlate_on = on; req_valid = 1'b1;
        @(negedge clk);
        lat = 1; rd = 0;
        if (poke) begin
            req_vaddr = ~va; req_root = root + 64'h1000; req_xlate_on = ~on;
        end else begin
            req_valid = 1'b0;
        end
        while (!rsp_valid && lat < 40) begin
            if (mem_rd_valid) rd++;
            if (poke && req_ready) chk(1'b0, {tag, " R11 ready while busy"}, 64'd1, 64'd0);
            @(negedge clk);
            lat++;
        end
        req_valid = 1'b0;
        chk(rsp_valid === 1'b1 && lat == e_lat, {tag, " R12 latency"}, 64'(lat), 64'(e_lat));
        chk(rsp_fault === e_flt, {tag, " fault flag"}, 64'(rsp_fault), 64'(e_flt));
        chk(rsp_entry === e_ent, e_flt ? {tag, " R9 entry"} : {tag, " entry"}, rsp_entry, e_ent);
        chk(rd == e_rd, {tag, " R10 reads"}, 64'(rd), 64'(e_rd));
        @(negedge clk);
        chk(!rsp_valid && req_ready, {tag, " R11 pulse/idle"}, {62'd0, rsp_valid, req_ready}, 64'd1);
    endtask

    task automatic fill_random();
        for (int i = 0; i < 4096; i++) begin
            int unsigned t;
            logic [63:0] w;
            t = $urandom_range(0, 9);
            w = {$urandom, $urandom};
            if (t < 4) begin
                w = (64'($urandom_range(0, 8)) << 12) | 64'h1;
            end else if (t < 7) begin
                w = {20'h0, w[43:12], w[11:2], 2'b10} | 64'($urandom_range(0, 1));
            end else begin
                w[1:0] = 2'b00;
            end
            mem[i] = w;
        end
    endtask

    localparam logic [63:0] VA_D = (64'd1 << 39) | (64'd2 << 30) | (64'd3 << 21) | (64'd4 << 12) | 64'hABC;

    task automatic chain();
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        mem[1]        = (64'd1 << 12) | 64'h1;
        mem[512 + 2]  = (64'd2 << 12) | 64'h1;
        mem[1024 + 3] = (64'd3 << 12) | 64'h1;
        mem[1536 + 4] = (64'hABCDE << 12) | 64'h0FA;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_rd_valid === 1'b0, "R1 reset state",
            {61'd0, req_ready, rsp_valid, mem_rd_valid}, 64'd4);

        // R2 identity, including a zero memory size
        walk(64'hFFFF_FFFF_FFFF_F123, 64'h0, 64'h8000, 1'b0, 1'b0, "R2 identity");
        walk(64'h0000_1234_5678_9ABC, 64'h0, 64'h0, 1'b0, 1'b0, "R2 identity no memory");

        // R5 superpage at level 0 with fold of 27 page bits
        chain();
        mem[1] = (64'h5_5555 << 12) | 64'h3F6;
        walk(VA_D, 64'h0, 64'h8000, 1'b1, 1'b0, "R5 level0 fold");

        // R7 R3 full descent to a level-3 leaf
        chain();
        walk(VA_D, 64'h0, 64'h8000, 1'b1, 1'b0, "R7 R3 four-level descent");
        walk(VA_D, 64'h0, 64'h8000, 1'b1, 1'b1, "R11 busy request ignored");

        // R5 both type bits set counts as leaf
        mem[1536 + 4] = (64'h77 << 12) | 64'h3;
        walk(VA_D, 64'h0, 64'h8000, 1'b1, 1'b0, "R5 leaf priority");

        // R8 table descriptor at last level
        mem[1536 + 4] = (64'd4 << 12) | 64'h1;
        walk(VA_D, 64'h0, 64'h8000, 1'b1, 1'b0, "R8 out of levels");

        // R6 invalid at level 1
        chain();
        mem[512 + 2] = 64'hFFFF_0000_0000_0F0C;
        walk(VA_D, 64'h0, 64'h8000, 1'b1, 1'b0, "R6 invalid level1");

        // R4 bound edges
        chain();
        walk(VA_D, 64'h0, 64'd8, 1'b1, 1'b0, "R4 bound equal");
        walk(VA_D, 64'h0, 64'd9, 1'b1, 1'b0, "R4 bound one above");
        walk(VA_D, 64'h0, 64'd4096 + 64'd16, 1'b1, 1'b0, "R4 bound level1");

        // R3 nonzero root
        mem[5 * 512 + 1] = (64'h9_9999 << 12) | 64'h102;
        walk(VA_D, 64'h5000, 64'h8000, 1'b1, 1'b0, "R3 root base");

        // random trees and addresses
        for (int n = 0; n < 12; n++) begin
            fill_random();
            for (int k = 0; k < 30; k++) begin
                logic [63:0] va, root, lim;
                bit on, poke;
                va   = {$urandom, $urandom};
                root = 64'($urandom_range(0, 7)) << 12;
                lim  = ($urandom_range(0, 3) == 0) ? 64'($urandom_range(1, 4096)) << 3 : 64'h8000;
                on   = ($urandom_range(0, 9) != 0);
                poke = ($urandom_range(0, 4) == 0);
                walk(va, root, lim, on, poke, "R3 R5 R6 R7 random");
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule